// File: doc/BRIEF.md
# Multi-Port Proportional-Integral Loop Filter

This block is the loop controller of a digital clock-recovery loop that serves several clients at once. Each client port delivers signed phase-difference samples. The block holds one pending sample per port and visits the ports in a fixed cyclic order, one port per clock. When the visited port has a pending sample, the block runs the proportional-plus-integral calculation for that port against its own integrator. It then emits one signed control value for the oscillator interface, tagged with the port number and a one-cycle valid strobe.

A simple write-only register port sets the controller. The settings are a signed proportional gain, an integral gain, a signed input offset, separate clamp limits for the integrator and the output, and a fast pull-in threshold with its step multiplier. The integral gain is an unsigned mantissa with a right-shift exponent, so it can be well below one. A further register selects one port for live monitoring. The monitor outputs show the offset-corrected input, the integrator and the control value for the last sample processed on that port.

Top module: `pi_loop_filter`

## Requirements
- R1: A poll pointer steps through ports 0,1,...,NPORT-1 and wraps, one step every clock. A port with a pending sample at its poll is processed at that edge. The result appears on `out_data` with `out_valid` high for one cycle and `out_port` naming the port. When all ports have samples pending, the results come out on consecutive cycles in cyclic port order.
- R2: Every sample is first corrected as x = sample + offset. The offset is signed, and x is computed at full width.
- R3: Each port has its own signed integrator, cleared by reset. Processing a sample sets the integrator to clamp(integrator + step, ±L). L is the integrator limit register, capped at 2^(ACC_W-1)-1.
- R4: The step is x*mult when |x| > threshold and x otherwise. The comparison is strict, so |x| equal to the threshold uses plain x.
- R5: The output is clamp(kp*x + ((acc*ki_m) >>> ki_s), ±M). Here acc is the integrator value after this sample, and >>> is an arithmetic shift that rounds toward minus infinity. M is the output limit register, capped at 2^(OUT_W-1)-1.
- R6: When no sample is processed, `out_valid` stays low and `out_data` keeps its last value.
- R7: Register writes take effect when `cfg_wr` is high at a clock edge. The addresses are:
  - 0: kp, signed, in bits KP_W-1:0.
  - 1: ki mantissa in bits KI_W-1:0, and ki shift in bits 16+KS_W-1:16.
  - 2: offset, signed, in bits IN_W-1:0.
  - 3: integrator limit, all ACC_W bits.
  - 4: output limit, in bits OUT_W-1:0.
  - 5: pull-in threshold, in bits IN_W-1:0.
  - 6: pull-in multiplier, in bits MUL_W-1:0.
  - 7: monitored port.
- R8: When the monitored port is processed, `mon_x`, `mon_acc` and `mon_y` are all loaded at the same edge with that sample's x, new integrator value and output. Processing any other port leaves them unchanged.
- R9: A new sample arriving in the same cycle that its port is polled stays pending, while the older sample is processed. A second sample for a port that arrives before that port is polled replaces the first, and only one result is produced.
- R10: Reset clears `out_valid`, `out_data`, the monitor outputs and every integrator. Reset also sets kp=1, ki mantissa=0, ki shift=0, offset=0, both limits and the threshold to all ones, multiplier=1 and monitored port=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | NPORT | Per-port sample strobe |
| smp_phase | input | NPORT*IN_W | Per-port signed phase samples, port p at bits p*IN_W upward |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | ACC_W | Register write data |
| out_valid | output | 1 | One-cycle result strobe |
| out_port | output | $clog2(NPORT) | Port of the current result |
| out_data | output | OUT_W | Signed control value |
| mon_x | output | IN_W+1 | Monitored port: corrected input |
| mon_acc | output | ACC_W | Monitored port: integrator |
| mon_y | output | OUT_W | Monitored port: control value |

## Verification
The capture of a fresh sample and the poll that clears a port's pending flag can fall on the same clock edge. The bench provokes this by timing off an observed result. One period after that result, a sample is made pending. A second sample is then driven exactly at the port's next poll edge. The check passes only if the first result carries the older sample and a second result later carries the newer one. A companion case drives two samples before the poll and expects a single result built from the newer sample.

// File: rtl/pi_pkg.sv
package pi_pkg;

   typedef enum logic [2:0] {
      REG_KP   = 3'd0,
      REG_KI   = 3'd1,
      REG_OFS  = 3'd2,
      REG_ISAT = 3'd3,
      REG_OSAT = 3'd4,
      REG_THR  = 3'd5,
      REG_MUL  = 3'd6,
      REG_MON  = 3'd7
   } pi_reg_e;

   localparam int KI_SHIFT_LSB = 16;

   // symmetric clamp of a wide signed value to +/-lim
   function automatic logic signed [63:0] clamp_sym(input logic signed [63:0] v,
                                                    input logic signed [63:0] lim);
      if (v > lim)       return lim;
      else if (v < -lim) return -lim;
      else               return v;
   endfunction

endpackage

// File: rtl/pi_sample_poller.sv
module pi_sample_poller #(
   parameter int NPORT  = 4,
   parameter int IN_W   = 16,
   localparam int PIDX_W = $clog2(NPORT)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NPORT-1:0]         smp_valid,
   input  logic [NPORT*IN_W-1:0]    smp_phase,
   output logic                     fire,
   output logic [PIDX_W-1:0]        fire_port,
   output logic signed [IN_W-1:0]   fire_sample
);

   logic [PIDX_W-1:0]        ptr_q;
   logic [NPORT-1:0]         pend_q;
   logic signed [IN_W-1:0]   hold_q [NPORT];

   always_ff @(posedge clk) begin
      if (rst)                                   ptr_q <= '0;
      else if (ptr_q == PIDX_W'(NPORT - 1))      ptr_q <= '0;
      else                                       ptr_q <= ptr_q + 1'b1;
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      always_ff @(posedge clk) begin
         if (rst) begin
            pend_q[p] <= 1'b0;
            hold_q[p] <= '0;
         end else if (smp_valid[p]) begin
            pend_q[p] <= 1'b1;
            hold_q[p] <= smp_phase[p*IN_W +: IN_W];
         end else if (ptr_q == PIDX_W'(p)) begin
            pend_q[p] <= 1'b0;
         end
      end

      // R9: a fresh sample is never lost to a simultaneous poll
      a_r9_capture_wins: assert property (@(posedge clk) disable iff (rst)
         smp_valid[p] |=> pend_q[p]);
   end

   assign fire        = pend_q[ptr_q];
   assign fire_port   = ptr_q;
   assign fire_sample = hold_q[ptr_q];

   // R1: pointer walks the ports cyclically
   a_r1_poll_advance: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ptr_q == (($past(ptr_q) == PIDX_W'(NPORT - 1)) ? '0 : $past(ptr_q) + 1'b1));

endmodule

// File: rtl/pi_datapath.sv
module pi_datapath
   import pi_pkg::*;
#(
   parameter int IN_W      = 16,
   parameter int ACC_W     = 32,
   parameter int OUT_W     = 24,
   parameter int KP_W      = 16,
   parameter int KI_W      = 16,
   parameter int KS_W      = 5,
   parameter int MUL_W     = 8,
   parameter bit PULLIN_EN = 1'b1,
   localparam int X_W      = IN_W + 1
) (
   input  logic signed [IN_W-1:0]  sample,
   input  logic signed [ACC_W-1:0] acc_old,
   input  logic signed [KP_W-1:0]  kp,
   input  logic [KI_W-1:0]         ki_m,
   input  logic [KS_W-1:0]         ki_s,
   input  logic signed [IN_W-1:0]  offset,
   input  logic [ACC_W-1:0]        isat,
   input  logic [OUT_W-1:0]        osat,
   input  logic [IN_W-1:0]         thr,
   input  logic [MUL_W-1:0]        mult,
   output logic signed [X_W-1:0]   x,
   output logic signed [ACC_W-1:0] acc_new,
   output logic signed [OUT_W-1:0] y
);

   localparam logic signed [63:0] ACC_MAX = (64'sd1 <<< (ACC_W - 1)) - 64'sd1;
   localparam logic signed [63:0] OUT_MAX = (64'sd1 <<< (OUT_W - 1)) - 64'sd1;

   logic signed [63:0] x64, mag64, step64, acc64, kit64, y64, ilim, olim;

   always_comb begin
      x64   = 64'(sample) + 64'(offset);
      mag64 = (x64 < 0) ? -x64 : x64;
      ilim  = ($signed(64'(isat)) > ACC_MAX) ? ACC_MAX : $signed(64'(isat));
      olim  = ($signed(64'(osat)) > OUT_MAX) ? OUT_MAX : $signed(64'(osat));
   end

   if (PULLIN_EN) begin : g_pullin
      always_comb
         step64 = (mag64 > $signed(64'(thr))) ? x64 * $signed(64'(mult)) : x64;
   end else begin : g_plain
      always_comb step64 = x64;
   end

   always_comb begin
      acc64 = clamp_sym(64'(acc_old) + step64, ilim);
      kit64 = (acc64 * $signed(64'(ki_m))) >>> ki_s;
      y64   = clamp_sym(x64 * 64'(kp) + kit64, olim);
   end

   assign x       = x64[X_W-1:0];
   assign acc_new = acc64[ACC_W-1:0];
   assign y       = y64[OUT_W-1:0];

endmodule

// File: rtl/pi_integ_bank.sv
module pi_integ_bank #(
   parameter int NPORT  = 4,
   parameter int ACC_W  = 32,
   localparam int PIDX_W = $clog2(NPORT)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [PIDX_W-1:0]        port,
   output logic signed [ACC_W-1:0]  acc_rd,
   input  logic                     wr_en,
   input  logic signed [ACC_W-1:0]  acc_wr
);

   logic signed [ACC_W-1:0] integ_q [NPORT];

   for (genvar p = 0; p < NPORT; p++) begin : g_acc
      always_ff @(posedge clk) begin
         if (rst)                                 integ_q[p] <= '0;
         else if (wr_en && port == PIDX_W'(p))    integ_q[p] <= acc_wr;
      end
   end

   assign acc_rd = integ_q[port];

endmodule

// File: rtl/pi_loop_filter.sv
module pi_loop_filter
   import pi_pkg::*;
#(
   parameter int NPORT     = 4,
   parameter int IN_W      = 16,
   parameter int ACC_W     = 32,
   parameter int OUT_W     = 24,
   parameter int KP_W      = 16,
   parameter int KI_W      = 16,
   parameter int KS_W      = 5,
   parameter int MUL_W     = 8,
   parameter bit PULLIN_EN = 1'b1,
   localparam int PIDX_W   = $clog2(NPORT),
   localparam int X_W      = IN_W + 1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NPORT-1:0]         smp_valid,
   input  logic [NPORT*IN_W-1:0]    smp_phase,
   input  logic                     cfg_wr,
   input  logic [2:0]               cfg_addr,
   input  logic [ACC_W-1:0]         cfg_wdata,
   output logic                     out_valid,
   output logic [PIDX_W-1:0]        out_port,
   output logic signed [OUT_W-1:0]  out_data,
   output logic signed [X_W-1:0]    mon_x,
   output logic signed [ACC_W-1:0]  mon_acc,
   output logic signed [OUT_W-1:0]  mon_y
);

   if (NPORT < 2)                                  begin : g_bad_np  $error("NPORT must be at least 2"); end
   if (KI_W > KI_SHIFT_LSB)                        begin : g_bad_ki  $error("KI_W exceeds shift field position"); end
   if (KI_SHIFT_LSB + KS_W > ACC_W)                begin : g_bad_ks  $error("shift field beyond write data"); end
   if (KP_W > ACC_W || IN_W >= ACC_W || OUT_W > ACC_W || MUL_W > ACC_W)
                                                   begin : g_bad_w   $error("field wider than write data"); end
   if (ACC_W + KI_W + 2 > 63 || X_W + KP_W + 2 > 63 || X_W + MUL_W + 2 > 63)
                                                   begin : g_bad_dp  $error("datapath exceeds 64-bit arithmetic"); end

   // configuration registers
   logic signed [KP_W-1:0]  kp_q;
   logic [KI_W-1:0]         kim_q;
   logic [KS_W-1:0]         kis_q;
   logic signed [IN_W-1:0]  ofs_q;
   logic [ACC_W-1:0]        isat_q;
   logic [OUT_W-1:0]        osat_q;
   logic [IN_W-1:0]         thr_q;
   logic [MUL_W-1:0]        mul_q;
   logic [PIDX_W-1:0]       mon_sel_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         kp_q      <= KP_W'(1);
         kim_q     <= '0;
         kis_q     <= '0;
         ofs_q     <= '0;
         isat_q    <= '1;
         osat_q    <= '1;
         thr_q     <= '1;
         mul_q     <= MUL_W'(1);
         mon_sel_q <= '0;
      end else if (cfg_wr) begin
         case (pi_reg_e'(cfg_addr))
            REG_KP:   kp_q      <= cfg_wdata[KP_W-1:0];
            REG_KI: begin
                      kim_q     <= cfg_wdata[KI_W-1:0];
                      kis_q     <= cfg_wdata[KI_SHIFT_LSB +: KS_W];
            end
            REG_OFS:  ofs_q     <= cfg_wdata[IN_W-1:0];
            REG_ISAT: isat_q    <= cfg_wdata;
            REG_OSAT: osat_q    <= cfg_wdata[OUT_W-1:0];
            REG_THR:  thr_q     <= cfg_wdata[IN_W-1:0];
            REG_MUL:  mul_q     <= cfg_wdata[MUL_W-1:0];
            REG_MON:  mon_sel_q <= cfg_wdata[PIDX_W-1:0];
            default:  ;
         endcase
      end
   end

   logic                     fire;
   logic [PIDX_W-1:0]        fire_port;
   logic signed [IN_W-1:0]   fire_sample;
   logic signed [ACC_W-1:0]  acc_old, acc_new;
   logic signed [X_W-1:0]    x_c;
   logic signed [OUT_W-1:0]  y_c;

   pi_sample_poller #(.NPORT(NPORT), .IN_W(IN_W)) u_poll (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_phase(smp_phase),
      .fire(fire), .fire_port(fire_port), .fire_sample(fire_sample));

   pi_integ_bank #(.NPORT(NPORT), .ACC_W(ACC_W)) u_bank (
      .clk(clk), .rst(rst), .port(fire_port), .acc_rd(acc_old),
      .wr_en(fire), .acc_wr(acc_new));

   pi_datapath #(.IN_W(IN_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .KP_W(KP_W), .KI_W(KI_W),
                 .KS_W(KS_W), .MUL_W(MUL_W), .PULLIN_EN(PULLIN_EN)) u_dp (
      .sample(fire_sample), .acc_old(acc_old), .kp(kp_q), .ki_m(kim_q), .ki_s(kis_q),
      .offset(ofs_q), .isat(isat_q), .osat(osat_q), .thr(thr_q), .mult(mul_q),
      .x(x_c), .acc_new(acc_new), .y(y_c));

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_port  <= '0;
         out_data  <= '0;
         mon_x     <= '0;
         mon_acc   <= '0;
         mon_y     <= '0;
      end else begin
         out_valid <= fire;
         if (fire) begin
            out_port <= fire_port;
            out_data <= y_c;
            if (fire_port == mon_sel_q) begin
               mon_x   <= x_c;
               mon_acc <= acc_new;
               mon_y   <= y_c;
            end
         end
      end
   end

   // R6: without a result the control value does not move
   a_r6_hold_idle: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_data));

   // R5: a result never exceeds the output limit in force when it was formed
   a_r5_out_bounded: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (longint'(out_data) <= longint'($past(osat_q)) &&
                     longint'(out_data) >= -longint'($past(osat_q))));

   // R8: the monitor follows the selected port's result
   a_r8_monitor_tracks: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_port == $past(mon_sel_q)) |-> mon_y == out_data);

endmodule

// File: tb/pi_loop_filter_tb.sv
module pi_loop_filter_tb;

   localparam int NP    = 4;
   localparam int IN_W  = 16;
   localparam int ACC_W = 32;
   localparam int OUT_W = 24;
   localparam int PW    = $clog2(NP);

   logic                     clk = 1'b0;
   logic                     rst = 1'b1;
   logic [NP-1:0]            smp_valid = '0;
   logic [NP*IN_W-1:0]       smp_phase = '0;
   logic                     cfg_wr = 1'b0;
   logic [2:0]               cfg_addr = '0;
   logic [ACC_W-1:0]         cfg_wdata = '0;
   logic                     out_valid;
   logic [PW-1:0]            out_port;
   logic signed [OUT_W-1:0]  out_data;
   logic signed [IN_W:0]     mon_x;
   logic signed [ACC_W-1:0]  mon_acc;
   logic signed [OUT_W-1:0]  mon_y;

   pi_loop_filter #(.NPORT(NP), .IN_W(IN_W), .ACC_W(ACC_W), .OUT_W(OUT_W)) u_dut (
      .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_phase(smp_phase),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .out_valid(out_valid), .out_port(out_port), .out_data(out_data),
      .mon_x(mon_x), .mon_acc(mon_acc), .mon_y(mon_y));

   always #5 clk = ~clk;

   int total = 0;
   int bad   = 0;

   // bench-side model state
   longint integ_m [NP];
   longint k_p, k_im, k_is, k_off, k_isat, k_osat, k_thr, k_mul;
   longint last_x, last_a;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint clampm(input longint v, input longint lim);
      if (v > lim)  return lim;
      if (v < -lim) return -lim;
      return v;
   endfunction

   task automatic predict(input int p, input longint s, output longint y);
      longint x, step, a, ilim, olim;
      ilim = (k_isat > 64'h7FFF_FFFF) ? 64'h7FFF_FFFF : k_isat;
      olim = (k_osat > 64'h7F_FFFF) ? 64'h7F_FFFF : k_osat;
      x    = s + k_off;
      step = (((x < 0) ? -x : x) > k_thr) ? x * k_mul : x;
      a    = clampm(integ_m[p] + step, ilim);
      integ_m[p] = a;
      y    = clampm(x * k_p + ((a * k_im) >>> k_is), olim);
      last_x = x;
      last_a = a;
   endtask

   task automatic wr(input int addr, input longint data);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 3'(addr); cfg_wdata = ACC_W'(data);
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic drive(input int p, input longint s);
      smp_valid[p] = 1'b1;
      smp_phase[p*IN_W +: IN_W] = IN_W'(s);
   endtask

   task automatic send(input int p, input longint s);
      @(negedge clk);
      drive(p, s);
      @(negedge clk);
      smp_valid = '0;
   endtask

   task automatic wait_out(input int p, output longint d, output bit got);
      got = 1'b0;
      d   = 0;
      for (int i = 0; i < 3 * NP; i++) begin
         @(negedge clk);
         if (out_valid && out_port == PW'(p)) begin
            got = 1'b1;
            d   = longint'(out_data);
            break;
         end
      end
   endtask

   task automatic one(input int p, input longint s, input string req);
      longint ey, d;
      bit got;
      predict(p, s, ey);
      send(p, s);
      wait_out(p, d, got);
      chk(got, {req, " result present"}, got, 1);
      chk(d == ey, req, d, ey);
   endtask

   task automatic t_reset();
      chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
      chk(out_data == 0, "R10 out_data after reset", out_data, 0);
      chk(mon_y == 0 && mon_acc == 0 && mon_x == 0, "R10 monitor after reset", mon_acc, 0);
      // default configuration: kp=1, ki=0, no offset, no pull-in
      one(3, 7, "R10 default config result");
   endtask

   task automatic t_config();
      wr(0, 3);                 k_p = 3;
      wr(1, (2 << 16) | 5);     k_im = 5; k_is = 2;
      wr(2, -4);                k_off = -4;
      wr(3, 1000);              k_isat = 1000;
      wr(4, 5000);              k_osat = 5000;
      wr(5, 200);               k_thr = 200;
      wr(6, 4);                 k_mul = 4;
      wr(7, 2);
   endtask

   task automatic t_basic();
      one(1, 20, "R2 R3 R5 R7 port1 positive");
      one(1, -7, "R2 R5 port1 negative floor shift");
      one(1, 50, "R3 R5 port1 accumulate");
   endtask

   task automatic t_pullin();
      one(0, 300, "R4 R3 pull-in positive clamps integrator");
      one(0, -250, "R4 pull-in negative");
      one(0, 204, "R4 magnitude equal to threshold no multiply");
   endtask

   task automatic t_sat();
      wr(4, 2000); k_osat = 2000;
      one(0, 1000, "R5 output clamp positive");
      one(0, -1000, "R5 R3 output and integrator clamp negative");
      chk(integ_m[0] == -1000, "R3 model integrator at limit", integ_m[0], -1000);
      wr(4, 5000); k_osat = 5000;
   endtask

   task automatic t_hold();
      longint d0;
      one(3, 15, "R6 setup result");
      d0 = longint'(out_data);
      begin
         bit ok = 1'b1;
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (out_valid || longint'(out_data) != d0) ok = 1'b0;
         end
         chk(ok, "R6 output holds while idle", longint'(out_data), d0);
      end
   endtask

   task automatic t_order();
      longint ey [NP];
      int first;
      for (int p = 0; p < NP; p++) predict(p, 10 * (p + 1), ey[p]);
      @(negedge clk);
      for (int p = 0; p < NP; p++) drive(p, 10 * (p + 1));
      @(negedge clk);
      smp_valid = '0;
      first = -1;
      for (int i = 0; i < 2 * NP && first < 0; i++) begin
         if (out_valid) first = int'(out_port);
         else @(negedge clk);
      end
      chk(first >= 0, "R1 burst result present", first, 0);
      if (first >= 0) begin
         for (int k = 0; k < NP; k++) begin
            int ep = (first + k) % NP;
            chk(out_valid && out_port == PW'(ep), "R1 cyclic port order", out_port, ep);
            chk(longint'(out_data) == ey[ep], "R1 burst result value", out_data, ey[ep]);
            @(negedge clk);
         end
      end
   endtask

   task automatic t_monitor();
      longint ey, sx, sa, sy;
      bit got;
      longint d;
      predict(2, 33, ey);
      send(2, 33);
      wait_out(2, d, got);
      chk(got && mon_y == ey, "R8 monitor output", mon_y, ey);
      chk(mon_x == last_x, "R8 monitor input", mon_x, last_x);
      chk(mon_acc == last_a, "R8 monitor integrator", mon_acc, last_a);
      sx = mon_x; sa = mon_acc; sy = mon_y;
      one(0, 12, "R8 other port processed");
      chk(mon_x == sx && mon_acc == sa && mon_y == sy, "R8 monitor unchanged by other port", mon_y, sy);
   endtask

   task automatic t_collide();
      longint ea, eb, d;
      bit got;
      one(1, 5, "R9 alignment result");
      // now just after the edge that produced port 1's result
      predict(1, 40, ea);
      drive(1, 40);
      @(negedge clk); smp_valid = '0;
      @(negedge clk);
      @(negedge clk); drive(1, -60);
      predict(1, -60, eb);
      @(negedge clk); smp_valid = '0;
      chk(out_valid && out_port == PW'(1) && longint'(out_data) == ea,
          "R9 older sample processed at collision", out_data, ea);
      wait_out(1, d, got);
      chk(got && d == eb, "R9 colliding sample kept and processed", d, eb);
   endtask

   task automatic t_overwrite();
      longint eb, dummy;
      bit stray;
      one(2, 3, "R9 alignment result");
      drive(2, 111);
      @(negedge clk); drive(2, 77);
      @(negedge clk); smp_valid = '0;
      predict(2, 77, eb);
      @(negedge clk);
      @(negedge clk);
      chk(out_valid && out_port == PW'(2) && longint'(out_data) == eb,
          "R9 later sample replaces earlier", out_data, eb);
      stray = 1'b0;
      for (int i = 0; i < 2 * NP; i++) begin
         @(negedge clk);
         if (out_valid && out_port == PW'(2)) stray = 1'b1;
      end
      dummy = stray;
      chk(!stray, "R9 single result for replaced sample", dummy, 0);
   endtask

   initial begin
      for (int p = 0; p < NP; p++) integ_m[p] = 0;
      k_p = 1; k_im = 0; k_is = 0; k_off = 0;
      k_isat = 64'hFFFF_FFFF; k_osat = 64'hFF_FFFF; k_thr = 64'hFFFF; k_mul = 1;
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_config();
      t_basic();
      t_pullin();
      t_sat();
      t_hold();
      t_order();
      t_monitor();
      t_collide();
      t_overwrite();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1_000_000;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule